// File: doc/BRIEF.md
# Stateful Memory Access Reference Monitor

This block sits between two bus masters and a shared peripheral bus and rules on every bus request. A request carries a valid strobe, a master select, a read/write flag and a 32-bit address. The address is compared in parallel against a fixed set of address windows, which yields a window ID. The master, the operation and the window ID then drive a three-state policy machine. That machine controls time-shared ownership of one crypto accelerator, and it returns a single grant/deny bit one clock later.

Each master has a private isolation domain: its own DRAM half and its own I/O port, plus a shared debug window. The crypto accelerator, with its control word, belongs to at most one master at a time. A master takes ownership by writing an acquire word and gives it back by writing a release word. A saturating counter records the denied requests, and a sticky flag that software can clear records that a violation has occurred.

The request side has no back-pressure. The block accepts a request on every cycle that `req_valid` is high, and each accepted request produces exactly one decision strobe, in order.

Top module: `access_monitor`

## Requirements
- R1: For every cycle with `req_valid` high, `dec_valid` is high exactly one cycle later. `dec_valid` is low one cycle after every cycle with `req_valid` low. `dec_grant` is never high while `dec_valid` is low.
- R2: Window decode uses priority. The acquire word 0x28000004–0x28000007, the release word 0x28000008–0x2800000F and the crypto control word 0x28000000–0x28000003 take precedence over the crypto-1 window 0x28000000–0x28000777. The crypto-2 window is 0x28000800–0x28000FFF. An address inside no window is always denied.
- R3: In every policy state, master 1 (`req_master`=0) may read and write debug 0x41400000–0x4140FFFF, DRAM-1 0x24000000–0x24777777 and serial 0x40600000–0x4060FFFF. Master 2 (`req_master`=1) may read and write debug, DRAM-2 0x24800000–0x24FFFFFF and network 0x40C00000–0x40C0FFFF. Any access by one master to the other master's DRAM or I/O window is denied.
- R4: Synchronous reset (`rst`=1) selects the no-owner state and clears `dec_valid`, `dec_grant`, `deny_count` and `violation`. In the no-owner state, crypto and control-word accesses are denied.
- R5: In the no-owner state, a write (`req_write`=1) to the acquire word by master N is granted and makes master N the owner. An acquire write by either master while the core is owned is denied and leaves the owner unchanged.
- R6: The owner may read and write its own crypto window (crypto-1 for master 1, crypto-2 for master 2) and the crypto control word. The other master is denied both.
- R7: A write to the release word by the owner is granted and returns the machine to the no-owner state. A release write by the non-owner is denied and leaves the state unchanged. Any read of the acquire or release word is denied.
- R8: A state change caused by a request applies to the very next request, including when the next request follows back-to-back.
- R9: `deny_count` increments by one for every denied request, in the same cycle that the deny appears, and saturates at 0xFFFF.
- R10: `violation` sets on any deny and stays set until a cycle with `viol_clear` high. A deny in the same cycle as `viol_clear` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 1 | 0 = master 1, 1 = master 2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| viol_clear | input | 1 | Clears the sticky violation flag |
| dec_valid | output | 1 | Decision strobe, one cycle after the request |
| dec_grant | output | 1 | 1 = grant, 0 = deny (qualified by dec_valid) |
| deny_count | output | 16 | Saturating count of denied requests |
| violation | output | 1 | Sticky flag, set by any deny |

## Verification
The policy is exercised with request streams that walk each master through every window in each of the three owner states, so that a mix-up between the masters' domains, a wrong state or a swapped window shows up as a flipped grant. Addresses right at window edges and in the gaps between them separate the priority and boundary logic from the plain decode. An acquire write by master 1 is itself the proof of priority: without the precedence rule it would decode as crypto-1 and be denied. Back-to-back acquire/use and release/use pairs show that the state takes effect on the next request, and a long run of denies reaches counter saturation.

// File: rtl/access_monitor_pkg.sv
package access_monitor_pkg;
  localparam int N_RANGES = 10;
  localparam int RID_W    = $clog2(N_RANGES + 1);

  // window IDs; index order of the table below sets match priority
  localparam logic [RID_W-1:0] RID_NONE  = 4'd0;
  localparam logic [RID_W-1:0] RID_ACQ   = 4'd1;
  localparam logic [RID_W-1:0] RID_REL   = 4'd2;
  localparam logic [RID_W-1:0] RID_CCW   = 4'd3;
  localparam logic [RID_W-1:0] RID_DBG   = 4'd4;
  localparam logic [RID_W-1:0] RID_CRY1  = 4'd5;
  localparam logic [RID_W-1:0] RID_CRY2  = 4'd6;
  localparam logic [RID_W-1:0] RID_DRAM1 = 4'd7;
  localparam logic [RID_W-1:0] RID_DRAM2 = 4'd8;
  localparam logic [RID_W-1:0] RID_SER   = 4'd9;
  localparam logic [RID_W-1:0] RID_NET   = 4'd10;

  typedef enum logic [1:0] {ST_FREE = 2'd0, ST_OWN1 = 2'd1, ST_OWN2 = 2'd2} own_state_t;

  function automatic logic [31:0] win_lo(input int idx);
    case (idx)
      0: win_lo = 32'h2800_0004;
      1: win_lo = 32'h2800_0008;
      2: win_lo = 32'h2800_0000;
      3: win_lo = 32'h4140_0000;
      4: win_lo = 32'h2800_0000;
      5: win_lo = 32'h2800_0800;
      6: win_lo = 32'h2400_0000;
      7: win_lo = 32'h2480_0000;
      8: win_lo = 32'h4060_0000;
      default: win_lo = 32'h40C0_0000;
    endcase
  endfunction

  function automatic logic [31:0] win_hi(input int idx);
    case (idx)
      0: win_hi = 32'h2800_0007;
      1: win_hi = 32'h2800_000F;
      2: win_hi = 32'h2800_0003;
      3: win_hi = 32'h4140_FFFF;
      4: win_hi = 32'h2800_0777;
      5: win_hi = 32'h2800_0FFF;
      6: win_hi = 32'h2477_7777;
      7: win_hi = 32'h24FF_FFFF;
      8: win_hi = 32'h4060_FFFF;
      default: win_hi = 32'h40C0_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/mon_range_match.sv
module mon_range_match
  import access_monitor_pkg::*;
#(
  parameter int AW = 32,
  parameter int NR = N_RANGES,
  localparam int IW = $clog2(NR + 1)
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] rid
);
  logic [NR-1:0] hit;

  for (genvar i = 0; i < NR; i++) begin : g_win
    assign hit[i] = (addr >= AW'(win_lo(i))) && (addr <= AW'(win_hi(i)));
  end

  // lowest table index wins
  always_comb begin
    rid = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (hit[i]) rid = IW'(i + 1);
    end
  end
endmodule

// File: rtl/mon_policy.sv
module mon_policy
  import access_monitor_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_m2,
  input  logic             req_write,
  input  logic [RID_W-1:0] rid,
  output logic             permit
);
  own_state_t state, state_nxt;
  logic       is_owner;
  logic       own_crypto;

  assign is_owner   = (state == ST_OWN1 && !req_m2) || (state == ST_OWN2 && req_m2);
  assign own_crypto = req_m2 ? (rid == RID_CRY2) : (rid == RID_CRY1);

  always_comb begin
    permit    = 1'b0;
    state_nxt = state;
    unique case (rid)
      RID_DBG:   permit = 1'b1;
      RID_DRAM1,
      RID_SER:   permit = !req_m2;
      RID_DRAM2,
      RID_NET:   permit = req_m2;
      RID_CRY1,
      RID_CRY2:  permit = is_owner && own_crypto;
      RID_CCW:   permit = is_owner;
      RID_ACQ: begin
        permit = req_write && (state == ST_FREE);
        if (req_valid && permit) state_nxt = req_m2 ? ST_OWN2 : ST_OWN1;
      end
      RID_REL: begin
        permit = req_write && is_owner;
        if (req_valid && permit) state_nxt = ST_FREE;
      end
      default:   permit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FREE;
    else     state <= state_nxt;
  end
endmodule

// File: rtl/mon_deny_stats.sv
module mon_deny_stats #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          deny_evt,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          flag
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      if (deny_evt && count != CNT_MAX) count <= count + 1'b1;
      if (deny_evt)   flag <= 1'b1;
      else if (clear) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/access_monitor.sv
module access_monitor
  import access_monitor_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_master,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              viol_clear,
  output logic              dec_valid,
  output logic              dec_grant,
  output logic [CNT_W-1:0]  deny_count,
  output logic              violation
);
  logic [RID_W-1:0] rid;
  logic             permit;
  logic             deny_now;

  mon_range_match #(.AW(ADDR_W), .NR(N_RANGES)) u_match (
    .addr (req_addr),
    .rid  (rid)
  );

  mon_policy u_policy (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_m2    (req_master),
    .req_write (req_write),
    .rid       (rid),
    .permit    (permit)
  );

  assign deny_now = req_valid && !permit;

  mon_deny_stats #(.CW(CNT_W)) u_stats (
    .clk      (clk),
    .rst      (rst),
    .deny_evt (deny_now),
    .clear    (viol_clear),
    .count    (deny_count),
    .flag     (violation)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_grant <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      dec_grant <= req_valid && permit;
    end
  end
endmodule

// File: rtl/access_monitor_chk.sv
module access_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_master,
  input logic [ADDR_W-1:0] req_addr,
  input logic              viol_clear,
  input logic              dec_valid,
  input logic              dec_grant,
  input logic [CNT_W-1:0]  deny_count,
  input logic              violation
);
  logic [7:0] top_byte;
  assign top_byte = req_addr[ADDR_W-1 -: 8];

  // R1
  dec_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  // R1
  no_spurious_dec_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);
  // R1
  grant_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    dec_grant |-> dec_valid);
  // R2
  unmapped_denied_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && top_byte != 8'h24 && top_byte != 8'h28 &&
     top_byte != 8'h40 && top_byte != 8'h41) |=> !dec_grant);
  // R3
  m1_no_dram2_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_master && req_addr >= 32'h2480_0000 &&
     req_addr <= 32'h24FF_FFFF) |=> !dec_grant);
  // R3
  m2_no_dram1_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_master && req_addr >= 32'h2400_0000 &&
     req_addr <= 32'h2477_7777) |=> !dec_grant);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_grant && $past(deny_count) != '1 && !$past(rst))
      |-> deny_count == $past(deny_count) + 1'b1);
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dec_valid || dec_grant) && !$past(rst) |-> $stable(deny_count));
  // R10
  flag_on_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_grant) |-> violation);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (violation && !viol_clear) |=> violation);
endmodule

bind access_monitor access_monitor_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_master (req_master),
  .req_addr   (req_addr),
  .viol_clear (viol_clear),
  .dec_valid  (dec_valid),
  .dec_grant  (dec_grant),
  .deny_count (deny_count),
  .violation  (violation)
);

// File: tb/access_monitor_bench.sv
`timescale 1ns/1ps
module access_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_master = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        viol_clear = 1'b0;
  logic        dec_valid, dec_grant, violation;
  logic [15:0] deny_count;

  int checks = 0;
  int errors = 0;
  int exp_denies = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  access_monitor u_access_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_master(req_master),
    .req_write(req_write), .req_addr(req_addr), .viol_clear(viol_clear),
    .dec_valid(dec_valid), .dec_grant(dec_grant),
    .deny_count(deny_count), .violation(violation)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one request per call, expected result into the scoreboard
  task automatic send(input bit m2, input bit wr, input logic [31:0] a, input bit exp, input string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_master = m2;
    req_write  = wr;
    req_addr   = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    if (!exp) exp_denies++;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops one expected item per decision strobe
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected decision", 32'(dec_valid), 32'd0);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 32'(dec_grant), 32'(e));
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset dec_valid", 32'(dec_valid), 0);
    check("R4 reset deny_count", 32'(deny_count), 0);
    check("R4 reset violation", 32'(violation), 0);
    rst = 1'b0;

    // static domains
    send(0, 1, 32'h4140_0010, 1, "R3 m1 write debug");
    send(1, 0, 32'h4140_FFFF, 1, "R3 m2 read debug top edge");
    send(0, 1, 32'h2400_0100, 1, "R3 m1 write dram1");
    send(0, 0, 32'h2480_0000, 0, "R3 m1 read dram2");
    send(1, 1, 32'h24FF_FFFF, 1, "R3 m2 write dram2");
    send(1, 0, 32'h2477_7777, 0, "R3 m2 read dram1 edge");
    send(0, 0, 32'h4060_0004, 1, "R3 m1 read serial");
    send(0, 1, 32'h40C0_0000, 0, "R3 m1 write network");
    send(1, 0, 32'h40C0_FFFF, 1, "R3 m2 read network");
    send(1, 1, 32'h4060_0000, 0, "R3 m2 write serial");
    send(0, 0, 32'h2477_7778, 0, "R2 gap after dram1");
    send(0, 0, 32'h4141_0000, 0, "R2 just past debug");
    send(1, 0, 32'h0000_0000, 0, "R2 unmapped zero");
    // no owner
    send(0, 0, 32'h2800_0100, 0, "R4 m1 crypto1 while free");
    send(0, 1, 32'h2800_0000, 0, "R4 m1 control word while free");
    send(0, 0, 32'h2800_0004, 0, "R7 read acquire word");
    send(0, 1, 32'h2800_000C, 0, "R7 release while free");
    // master 1 takes the core
    send(0, 1, 32'h2800_0004, 1, "R2 R5 m1 acquire");
    send(0, 1, 32'h2800_0100, 1, "R8 m1 crypto1 right after acquire");
    send(1, 1, 32'h2800_0006, 0, "R5 m2 acquire while owned");
    send(0, 1, 32'h2800_0007, 0, "R5 m1 acquire while owned");
    send(1, 0, 32'h2800_0800, 0, "R6 m2 crypto2 not owner");
    send(1, 1, 32'h2800_0000, 0, "R6 m2 control word not owner");
    send(0, 0, 32'h2800_0003, 1, "R6 m1 control word");
    send(0, 0, 32'h2800_0800, 0, "R6 m1 crypto2");
    send(0, 0, 32'h2800_0777, 1, "R2 crypto1 top edge");
    send(0, 0, 32'h2800_0778, 0, "R2 gap after crypto1");
    send(0, 0, 32'h2800_0008, 0, "R7 read release word");
    send(1, 1, 32'h2800_000F, 0, "R7 release by non-owner");
    send(0, 0, 32'h2800_0010, 1, "R7 owner kept after bad release");
    send(0, 1, 32'h2800_000C, 1, "R7 m1 release");
    send(0, 0, 32'h2800_0100, 0, "R8 m1 crypto1 right after release");
    // master 2 takes the core
    send(1, 1, 32'h2800_0006, 1, "R5 m2 acquire");
    send(1, 1, 32'h2800_0FFF, 1, "R6 m2 crypto2 top edge");
    send(1, 0, 32'h2800_0001, 1, "R6 m2 control word");
    send(0, 0, 32'h2800_0002, 0, "R6 m1 control word not owner");
    send(0, 0, 32'h2800_0100, 0, "R6 m1 crypto1 not owner");
    send(0, 1, 32'h2800_0004, 0, "R5 m1 acquire while m2 owns");
    send(1, 1, 32'h2800_0008, 1, "R7 m2 release");
    send(1, 0, 32'h2800_0800, 0, "R8 m2 crypto2 after release");
    idle();
    @(negedge clk);
    check("R1 no decision when idle", 32'(dec_valid), 0);
    check("R9 deny count", 32'(deny_count), 32'(exp_denies));
    check("R10 flag set", 32'(violation), 1);

    viol_clear = 1'b1;
    @(negedge clk);
    viol_clear = 1'b0;
    @(negedge clk);
    check("R10 flag cleared", 32'(violation), 0);
    send(1, 1, 32'h4060_0000, 0, "R10 deny with clear");
    viol_clear = 1'b1;
    idle();
    viol_clear = 1'b0;
    @(negedge clk);
    check("R10 set wins over clear", 32'(violation), 1);

    for (int k = 0; k < 65600; k++) send(0, 0, 32'h40C0_0000, 0, "R9 deny stream");
    idle();
    @(negedge clk);
    check("R9 saturated", 32'(deny_count), 32'h0000_FFFF);
    check("R1 scoreboard drained", 32'(exp_q.size()), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule